// File: doc/BRIEF.md
# Low-Latency Receive Path Selector

This block decides how received bytes travel toward the host DMA request logic. It has two modes. In buffered mode, receive data is staged in the on-chip buffer memory, and a DMA request is raised only after 64 bytes of the frame have arrived. That is long enough for a collision to show itself. In low-latency mode, receive data takes a fast path around the buffer memory, and the DMA request is raised after only 16 bytes, without waiting out the collision window. Transmit traffic always goes through the buffer. The transmit/receive boundary setting plays no part here.

Software asks for low-latency mode with a single configuration bit. The request takes effect only when a buffer is configured, meaning the buffer size is non-zero. The block latches a new mode only while the controller is stopped. A request written while the controller runs waits until the next stop. Per frame, the block counts accepted bytes from the frame-start marker onward. It raises the DMA request at the threshold for the current mode and drops it at frame end.

Top module: `llrx_path_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `lowlat_active`, `path_bypass` and `dma_req` are all 0.
- R2: At each clock edge where `ctl_run` is 0, the effective mode `lowlat_active` takes the value `cfg_lowlat_req` AND (`cfg_buf_pages` != 0). The new value is visible after that edge.
- R3: When `cfg_buf_pages` is 0 at a stopped edge, the request bit is ignored and `lowlat_active` becomes 0.
- R4: At every edge where `ctl_run` is 1, `lowlat_active` and `path_bypass` keep their values, whatever `cfg_lowlat_req` and `cfg_buf_pages` do.
- R5: `path_bypass` is 1 (receive data around the buffer) exactly when the effective mode is low latency. It is 0 (receive data through the buffer) otherwise.
- R6: In low-latency mode, `dma_req` is 1 after the edge that accepts the 16th byte of a frame. The byte carrying `rx_sof` counts as byte 1.
- R7: In buffered mode, `dma_req` stays 0 through byte 63 and is 1 after the edge that accepts byte 64.
- R8: A byte accepted with `rx_eof` = 1 ends the frame. After that edge, `dma_req` is 0 and the count is cleared. This holds even when the same byte would reach the threshold.
- R9: A byte accepted with `rx_sof` = 1 restarts the count at 1. When the threshold is above 1, `dma_req` is 0 after that edge.
- R10: While `ctl_run` is 0, byte strobes are ignored. Every stopped edge clears the count and `dma_req`.
- R11: `rx_sof` and `rx_eof` have no effect unless `rx_byte_vld` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_run | input | 1 | 1 = controller running, 0 = stopped |
| cfg_lowlat_req | input | 1 | Request for low-latency receive mode |
| cfg_buf_pages | input | SIZE_W | Configured buffer size; 0 means no buffer |
| rx_byte_vld | input | 1 | One received byte accepted this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| path_bypass | output | 1 | 1 = receive fast path, 0 = via buffer memory |
| lowlat_active | output | 1 | Effective low-latency mode |
| dma_req | output | 1 | DMA request toward the host bus unit |

## Verification
Two pairs of functions can fall on the same byte:
- **Threshold and frame end.** A frame can end on exactly its 16th byte in low-latency mode.
- **Frame start and an active request.** A frame-start marker can arrive while a request from the previous frame is still high.

The bench drives both cases on purpose. Its behavioural model gives frame end priority, and the start marker restarts the count from 1. The bench compares every output on every clock.

It also toggles the mode request and the buffer size while the controller runs. This checks that the effective mode moves only at stopped edges.

// File: rtl/llrx_pkg.sv
package llrx_pkg;

    typedef enum logic {
        PATH_BUFFERED = 1'b0,
        PATH_BYPASS   = 1'b1
    } rx_path_e;

    typedef struct packed {
        logic     active;
        rx_path_e path;
    } mode_state_t;

endpackage

// File: rtl/llrx_mode_ctl.sv
module llrx_mode_ctl
    import llrx_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_run,
    input  logic              cfg_lowlat_req,
    input  logic [SIZE_W-1:0] cfg_buf_pages,
    output logic              lowlat_active,
    output rx_path_e          path_sel
);

    mode_state_t st_d, st_q;
    logic        buf_present;

    always_comb begin
        buf_present = (cfg_buf_pages != '0);
        st_d        = st_q;
        // the mode is sampled only while stopped; a running controller keeps it
        if (!ctl_run) begin
            st_d.active = cfg_lowlat_req & buf_present;
            st_d.path   = (cfg_lowlat_req & buf_present) ? PATH_BYPASS : PATH_BUFFERED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, path: PATH_BUFFERED};
        end else begin
            st_q <= st_d;
        end
    end

    assign lowlat_active = st_q.active;
    assign path_sel      = st_q.path;

endmodule

// File: rtl/llrx_byte_cnt.sv
module llrx_byte_cnt #(
    parameter int LL_BYTES   = 16,
    parameter int NORM_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_run,
    input  logic lowlat,
    input  logic byte_vld,
    input  logic sof,
    input  logic eof,
    output logic dma_req
);

    localparam int MAX_THR = (NORM_BYTES > LL_BYTES) ? NORM_BYTES : LL_BYTES;
    localparam int CNT_W   = $clog2(MAX_THR + 1);
    localparam logic [CNT_W-1:0] LL_THR  = CNT_W'(LL_BYTES);
    localparam logic [CNT_W-1:0] NM_THR  = CNT_W'(NORM_BYTES);
    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(MAX_THR);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        thr  = lowlat ? LL_THR : NM_THR;
        base = sof ? '0 : st_q.cnt;
        // saturate once every threshold is already met
        nxt  = (base >= SAT_VAL) ? base : base + 1'b1;
        st_d = st_q;
        if (!ctl_run) begin
            st_d.cnt = '0;
            st_d.req = 1'b0;
        end else if (byte_vld) begin
            if (eof) begin
                // frame end wins over a threshold reached on the same byte
                st_d.cnt = '0;
                st_d.req = 1'b0;
            end else begin
                st_d.cnt = nxt;
                st_d.req = (nxt >= thr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dma_req = st_q.req;

endmodule

// File: rtl/llrx_path_sel.sv
module llrx_path_sel
    import llrx_pkg::*;
#(
    parameter int SIZE_W     = 8,
    parameter int LL_BYTES   = 16,
    parameter int NORM_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_run,
    input  logic              cfg_lowlat_req,
    input  logic [SIZE_W-1:0] cfg_buf_pages,
    input  logic              rx_byte_vld,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              path_bypass,
    output logic              lowlat_active,
    output logic              dma_req
);

    rx_path_e path_sel;
    logic     mode_ll;

    llrx_mode_ctl #(.SIZE_W(SIZE_W)) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_run        (ctl_run),
        .cfg_lowlat_req (cfg_lowlat_req),
        .cfg_buf_pages  (cfg_buf_pages),
        .lowlat_active  (mode_ll),
        .path_sel       (path_sel)
    );

    llrx_byte_cnt #(.LL_BYTES(LL_BYTES), .NORM_BYTES(NORM_BYTES)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_run  (ctl_run),
        .lowlat   (mode_ll),
        .byte_vld (rx_byte_vld),
        .sof      (rx_sof),
        .eof      (rx_eof),
        .dma_req  (dma_req)
    );

    assign lowlat_active = mode_ll;
    assign path_bypass   = (path_sel == PATH_BYPASS);

endmodule

// File: rtl/llrx_path_sel_chk.sv
module llrx_path_sel_chk #(
    parameter int SIZE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_run,
    input logic              cfg_lowlat_req,
    input logic [SIZE_W-1:0] cfg_buf_pages,
    input logic              rx_byte_vld,
    input logic              rx_sof,
    input logic              rx_eof,
    input logic              path_bypass,
    input logic              lowlat_active,
    input logic              dma_req
);

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_run |=> lowlat_active == $past(cfg_lowlat_req && (cfg_buf_pages != '0)));

    // R3
    no_buf_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && cfg_buf_pages == '0) |=> !lowlat_active);

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_run |=> ($stable(lowlat_active) && $stable(path_bypass)));

    // R5
    path_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_bypass == lowlat_active);

    // R8
    eof_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_run && rx_byte_vld && rx_eof) |=> !dma_req);

    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_run |=> !dma_req);

    // R11
    req_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(rx_byte_vld && ctl_run));

endmodule

bind llrx_path_sel llrx_path_sel_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_run        (ctl_run),
    .cfg_lowlat_req (cfg_lowlat_req),
    .cfg_buf_pages  (cfg_buf_pages),
    .rx_byte_vld    (rx_byte_vld),
    .rx_sof         (rx_sof),
    .rx_eof         (rx_eof),
    .path_bypass    (path_bypass),
    .lowlat_active  (lowlat_active),
    .dma_req        (dma_req)
);

// File: tb/llrx_path_sel_test.sv
`timescale 1ns/1ps
module llrx_path_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_run = 1'b0;
    logic       cfg_lowlat_req = 1'b0;
    logic [7:0] cfg_buf_pages = 8'd0;
    logic       rx_byte_vld = 1'b0;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic       path_bypass, lowlat_active, dma_req;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    int    m_mode = 0;
    int    m_cnt  = 0;
    int    m_req  = 0;
    string tag    = "R1";

    always #2 clk = ~clk;

    llrx_path_sel uut (
        .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run),
        .cfg_lowlat_req(cfg_lowlat_req), .cfg_buf_pages(cfg_buf_pages),
        .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .path_bypass(path_bypass), .lowlat_active(lowlat_active), .dma_req(dma_req)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(tag, "lowlat_active", int'(lowlat_active), m_mode);
        check("R5", "path_bypass", int'(path_bypass), m_mode);
        check(tag, "dma_req", int'(dma_req), m_req);
    endtask

    // drive at negedge, model the edge, compare at the following negedge
    task automatic step(input logic run, input logic llreq, input logic [7:0] pages,
                        input logic vld, input logic sof, input logic eof);
        ctl_run = run; cfg_lowlat_req = llreq; cfg_buf_pages = pages;
        rx_byte_vld = vld; rx_sof = sof; rx_eof = eof;
        @(posedge clk);
        if (!run) begin
            m_mode = (llreq && pages != 0) ? 1 : 0;
            m_cnt = 0; m_req = 0;
        end else if (vld) begin
            int start;
            start = sof ? 0 : m_cnt;
            if (eof) begin
                m_cnt = 0; m_req = 0;
            end else begin
                m_cnt = start + 1;
                m_req = (m_cnt >= (m_mode != 0 ? 16 : 64)) ? 1 : 0;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    // running frame of n bytes; last byte carries eof when with_eof
    task automatic frame(input logic llreq, input logic [7:0] pages, input int n, input bit with_eof);
        for (int i = 1; i <= n; i++) begin
            step(1'b1, llreq, pages, 1'b1, i == 1, with_eof && i == n);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R3: request ignored without buffer
        tag = "R3";
        step(1'b0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0);
        // R2: request taken while stopped with buffer present
        tag = "R2";
        step(1'b0, 1'b1, 8'd8, 1'b0, 1'b0, 1'b0);

        // R4: config toggled while running is held
        tag = "R4";
        step(1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 8'd8, 1'b0, 1'b0, 1'b0);

        // R6: low-latency request after 16 bytes, R8 drop at end
        tag = "R6";
        frame(1'b0, 8'd8, 20, 1'b0);
        tag = "R8";
        step(1'b1, 1'b0, 8'd8, 1'b1, 1'b0, 1'b1);
        // R8: eof on exactly the 16th byte wins
        frame(1'b0, 8'd8, 16, 1'b1);
        frame(1'b0, 8'd8, 15, 1'b1);

        // R9: new sof while request high restarts count
        tag = "R9";
        frame(1'b0, 8'd8, 18, 1'b0);
        frame(1'b0, 8'd8, 17, 1'b0);

        // R11: markers without byte strobe ignored
        tag = "R11";
        step(1'b1, 1'b0, 8'd8, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 8'd8, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'd8, 1'b1, 1'b0, 1'b0);

        // R10: stopped edge clears request, bytes ignored; mode reloads to buffered
        tag = "R10";
        step(1'b0, 1'b0, 8'd8, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 8'd8, 1'b1, 1'b0, 1'b0);

        // R7: buffered mode waits for 64 bytes; R4 request held while running
        tag = "R7";
        frame(1'b1, 8'd8, 66, 1'b0);
        step(1'b1, 1'b1, 8'd8, 1'b1, 1'b0, 1'b1);
        frame(1'b1, 8'd8, 64, 1'b1);

        // R2: stop again, mode now taken to low latency; R3 size zero drops it
        tag = "R2";
        step(1'b0, 1'b1, 8'd4, 1'b0, 1'b0, 1'b0);
        tag = "R3";
        step(1'b0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0);
        tag = "R7";
        frame(1'b1, 8'd0, 20, 1'b1);

        finish_run();
    end

endmodule